// File: doc/BRIEF.md
# Deep Power-Down Sequencing Controller

This block steps a small system into a deep power-down state and brings it back out. Software arms it through a power-control register: a power-down-enable bit, plus a flag that records that the last reset came from waking out of power-down. Five 32-bit retention registers hold data that must live through the power-down. The controller runs on an always-on clock. When software has armed it and the processor signals deep sleep together with a wait-for-interrupt strobe, the controller drops the regulator enable. Software must make sure the wake pin is high before this happens.

A low pulse on the wake pin wakes the system. The pulse is passed through a synchronizer and must stay low for at least a configured number of always-on cycles. On wake, the controller raises the regulator enable and waits for the core voltage-good input. It then drives a system reset request for a fixed number of cycles and returns to run. Only a power-on reset clears the retention registers and the power-control register. The wake reset sets the wake flag instead. The external reset pin is passed through as a reset request while the system runs, and has no effect while it is powered down.

Top module: `dpd_ctrl`

## Requirements
- R1: The controller leaves the run state only when, in one cycle, the enable bit (bit 0 of the control word at address 0) is 1, `cpu_sleepdeep` is 1, `cpu_wfi` is 1 and the synchronized wake pin is high. `reg_en` then reads 0 from the next cycle on.
- R2: In power-down, a wake pin low for at least `WAKE_MIN` consecutive always-on cycles (after a two-flop synchronizer) starts the wake-up. A shorter low pulse is ignored and `reg_en` stays 0.
- R3: `reg_en` is 0 only while powered down. During wake-up it is 1, and the controller waits with `sys_rst_req` low for as long as `vgood` is 0.
- R4: Once `vgood` is seen high during wake-up, `sys_rst_req` is high for exactly `RST_CYC` cycles, and the controller then returns to run.
- R5: The five retention registers (addresses 1 to 5) and the enable bit keep their values across a wake reset. `por_n` low clears them to 0.
- R6: The wake flag (bit 1 of the control word) becomes 1 only at the end of a wake reset. Writing 1 to that bit clears it, and writing 0 leaves it unchanged.
- R7: While running, `rst_pin_n` low drives `sys_rst_req` high two cycles later. While powered down, `rst_pin_n` has no effect on `sys_rst_req` or `reg_en`.
- R8: If the synchronized wake pin is low when the enter condition occurs, the controller stays in run and does not raise `sys_rst_req`.
- R9: Bus rules:
  - A request is taken on a cycle where both `req_valid` and `req_ready` are high.
  - `req_ready` is low unless the controller is running, and is also low while a response is pending with `rsp_ready` low.
  - Every accepted request gives one response the next cycle. Reads return the register value; writes and unmapped addresses return 0.
  - `rsp_valid` and `rsp_rdata` hold steady until `rsp_ready` is high.
- R10: A wait-for-interrupt strobe without the enable bit, or without `cpu_sleepdeep`, leaves the controller running with `reg_en` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Word address: 0 control, 1..5 retention |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response ready |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| cpu_sleepdeep | input | 1 | Processor deep-sleep qualifier |
| cpu_wfi | input | 1 | Wait-for-interrupt strobe |
| wake_n | input | 1 | External wake pin, asynchronous, active low |
| rst_pin_n | input | 1 | External reset pin, asynchronous, active low |
| vgood | input | 1 | Core voltage good |
| reg_en | output | 1 | Regulator enable |
| sys_rst_req | output | 1 | System reset request |

## Verification
Random wake pulses are drawn around `WAKE_MIN`, so lengths one cycle short and exactly at the limit both occur. A counter that is off by one would either wake on the short pulse or stay down on the exact one. Each round writes random retention data across a wake and reads it back, then reads the wake flag and clears it. This catches a design that lets the wake reset clear retained state, or that clears the flag when 0 is written. Directed cases target the remaining corners:
- A wake pin already low at entry, where a faulty design would power down for good.
- A reset pin pulled low while powered down, which a faulty design would pass through.
- A stalled response whose data must not change.
- The reset pulse length, counted once voltage-good rises.

// File: rtl/dpd_pkg.sv
package dpd_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_DOWN = 2'd1,
    ST_RAMP = 2'd2,
    ST_RST  = 2'd3
  } dpd_state_e;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_FLAG_BIT = 1;
endpackage

// File: rtl/dpd_sync.sv
module dpd_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dpd_wake_qual.sv
module dpd_wake_qual #(
  parameter int MIN_CYC = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic pin_low,
  output logic fire
);
  localparam int CW = $clog2(MIN_CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt <= '0;
    else if (!arm || !pin_low)      cnt <= '0;
    else if (cnt != CW'(MIN_CYC))   cnt <= cnt + 1'b1;
  end

  assign fire = arm && pin_low && (cnt == CW'(MIN_CYC - 1));

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(MIN_CYC)); // R2
  AST_CNT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_low |=> cnt == '0); // R2
endmodule

// File: rtl/dpd_regfile.sv
module dpd_regfile
  import dpd_pkg::*;
#(
  parameter int NUM_RET = 5,
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              bus_on,
  input  logic              soft_rst,
  input  logic              wake_done,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              pd_en
);
  logic              flag_q;
  logic [DATA_W-1:0] ret_q [NUM_RET];
  logic [DATA_W-1:0] rd_val;
  logic              acc, wr_fire, ctrl_wr;

  assign req_ready = bus_on && (!rsp_valid || rsp_ready);
  assign acc       = req_valid && req_ready;
  assign wr_fire   = acc && req_write;
  assign ctrl_wr   = wr_fire && (req_addr == '0);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pd_en  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (ctrl_wr) pd_en <= req_wdata[CTRL_EN_BIT];
      if (wake_done)                             flag_q <= 1'b1;
      else if (ctrl_wr && req_wdata[CTRL_FLAG_BIT]) flag_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < NUM_RET; g++) begin : g_ret
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                                       ret_q[g] <= '0;
      else if (wr_fire && req_addr == ADDR_W'(g + 1))   ret_q[g] <= req_wdata;
    end
  end

  always_comb begin
    rd_val = '0;
    if (req_addr == '0) begin
      rd_val[CTRL_EN_BIT]   = pd_en;
      rd_val[CTRL_FLAG_BIT] = flag_q;
    end
    for (int i = 0; i < NUM_RET; i++)
      if (req_addr == ADDR_W'(i + 1)) rd_val = ret_q[i];
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (soft_rst) begin
      rsp_valid <= 1'b0;
    end else if (acc) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= req_write ? '0 : rd_val;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_FLAG_ONLY_ON_WAKE: assert property (@(posedge clk) disable iff (!por_n)
    $rose(flag_q) |-> $past(wake_done)); // R6
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    (rsp_valid && !rsp_ready && !soft_rst) |=> (rsp_valid && $stable(rsp_rdata))); // R9
endmodule

// File: rtl/dpd_ctrl.sv
module dpd_ctrl
  import dpd_pkg::*;
#(
  parameter int NUM_RET  = 5,
  parameter int DATA_W   = 32,
  parameter int WAKE_MIN = 10,
  parameter int RST_CYC  = 4,
  localparam int ADDR_W  = $clog2(NUM_RET + 1)
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              cpu_sleepdeep,
  input  logic              cpu_wfi,
  input  logic              wake_n,
  input  logic              rst_pin_n,
  input  logic              vgood,
  output logic              reg_en,
  output logic              sys_rst_req
);
  localparam int RCW = $clog2(RST_CYC + 1);

  dpd_state_e     state;
  logic [RCW-1:0] rc;
  logic           wake_s, rst_s, wake_fire, pd_en, wake_done;

  dpd_sync #(.STAGES(2), .RST_VAL(1'b1)) u_wake_sync (
    .clk(clk), .rst_n(por_n), .d(wake_n), .q(wake_s));
  dpd_sync #(.STAGES(2), .RST_VAL(1'b1)) u_rst_sync (
    .clk(clk), .rst_n(por_n), .d(rst_pin_n), .q(rst_s));

  dpd_wake_qual #(.MIN_CYC(WAKE_MIN)) u_qual (
    .clk(clk), .rst_n(por_n), .arm(state == ST_DOWN),
    .pin_low(!wake_s), .fire(wake_fire));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state <= ST_RUN;
      rc    <= '0;
    end else begin
      unique case (state)
        ST_RUN:  if (pd_en && cpu_sleepdeep && cpu_wfi && wake_s) state <= ST_DOWN;
        ST_DOWN: if (wake_fire) state <= ST_RAMP;
        ST_RAMP: if (vgood) begin
                   state <= ST_RST;
                   rc    <= '0;
                 end
        ST_RST:  if (rc == RCW'(RST_CYC - 1)) state <= ST_RUN;
                 else                         rc    <= rc + 1'b1;
        default: state <= ST_RUN;
      endcase
    end
  end

  assign wake_done   = (state == ST_RST) && (rc == RCW'(RST_CYC - 1));
  assign reg_en      = (state != ST_DOWN);
  assign sys_rst_req = (state == ST_RST) || ((state == ST_RUN) && !rst_s);

  dpd_regfile #(.NUM_RET(NUM_RET), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .por_n(por_n), .bus_on(state == ST_RUN),
    .soft_rst(state == ST_RST), .wake_done(wake_done),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .pd_en(pd_en));

  AST_ENTER_QUALIFIED: assert property (@(posedge clk) disable iff (!por_n)
    (state == ST_DOWN && $past(state) == ST_RUN) |-> $past(pd_en && cpu_sleepdeep && cpu_wfi && wake_s)); // R1
  AST_WAKE_FROM_QUAL: assert property (@(posedge clk) disable iff (!por_n)
    (state == ST_RAMP && $past(state) == ST_DOWN) |-> $past(wake_fire)); // R2
  AST_RAMP_NEEDS_VGOOD: assert property (@(posedge clk) disable iff (!por_n)
    (state == ST_RST && $past(state) == ST_RAMP) |-> $past(vgood)); // R3
  AST_PIN_IGNORED_DOWN: assert property (@(posedge clk) disable iff (!por_n)
    (state == ST_DOWN && !rst_s) |-> !sys_rst_req); // R7
  AST_BUS_ONLY_IN_RUN: assert property (@(posedge clk) disable iff (!por_n)
    (req_valid && req_ready) |-> state == ST_RUN); // R9
endmodule

// File: tb/dpd_ctrl_test.sv
`timescale 1ns/1ps
module dpd_ctrl_test;
  localparam int WAKE_MIN = 10;
  localparam int RST_CYC  = 4;
  localparam int NUM_RET  = 5;

  logic        clk = 0, por_n = 0;
  logic        req_valid = 0, req_write = 0, rsp_ready = 1;
  logic [2:0]  req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic        req_ready, rsp_valid, reg_en, sys_rst_req;
  logic [31:0] rsp_rdata;
  logic        cpu_sleepdeep = 0, cpu_wfi = 0, wake_n = 1, rst_pin_n = 1, vgood = 0;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dpd_ctrl #(.NUM_RET(NUM_RET), .DATA_W(32), .WAKE_MIN(WAKE_MIN), .RST_CYC(RST_CYC)) uut (
    .clk(clk), .por_n(por_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .cpu_sleepdeep(cpu_sleepdeep), .cpu_wfi(cpu_wfi), .wake_n(wake_n),
    .rst_pin_n(rst_pin_n), .vgood(vgood), .reg_en(reg_en), .sys_rst_req(sys_rst_req));

  function automatic logic [31:0] ctrl_word(bit en, bit flag);
    return {30'b0, flag, en};
  endfunction

  function automatic bit should_wake(int len);
    return len >= WAKE_MIN;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    #0.1;
    while (!req_ready) begin @(negedge clk); #0.1; end
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic bus_rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    #0.1;
    while (!req_ready) begin @(negedge clk); #0.1; end
    @(negedge clk);
    d = rsp_rdata;
    req_valid = 0;
  endtask

  task automatic enter_dpd();
    @(negedge clk); cpu_sleepdeep = 1; cpu_wfi = 1;
    @(negedge clk); cpu_sleepdeep = 0; cpu_wfi = 0;
  endtask

  task automatic wake_pulse(int len);
    @(negedge clk); wake_n = 0;
    repeat (len) @(negedge clk);
    wake_n = 1;
    repeat (6) @(negedge clk);
  endtask

  task automatic finish_wake();
    int n;
    check(reg_en == 1, "R3 regulator on during wake", 32'(reg_en), 1);
    repeat (5) @(negedge clk);
    check(sys_rst_req == 0, "R3 waits for vgood", 32'(sys_rst_req), 0);
    vgood = 1;
    n = 0;
    repeat (RST_CYC + 6) begin @(negedge clk); if (sys_rst_req) n++; end
    check(n == RST_CYC, "R4 reset pulse length", 32'(n), 32'(RST_CYC));
    vgood = 0;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, hold;
    logic [31:0] vals [NUM_RET];
    void'($urandom(32'h1234ABCD));
    repeat (3) @(negedge clk);
    por_n = 1;
    repeat (2) @(negedge clk);

    // reset state
    check(reg_en == 1 && sys_rst_req == 0, "R3 reset outputs", {reg_en, sys_rst_req}, 32'h2);
    bus_rd(0, rd); check(rd == 0, "R5 control clear after POR", rd, 0);
    bus_rd(3, rd); check(rd == 0, "R5 retention clear after POR", rd, 0);

    // unmapped address
    bus_wr(6, 32'hDEADBEEF);
    bus_rd(6, rd); check(rd == 0, "R9 unmapped reads zero", rd, 0);

    // R10: enter without enable bit
    enter_dpd(); repeat (2) @(negedge clk);
    check(reg_en == 1, "R10 no enable stays run", 32'(reg_en), 1);
    bus_wr(0, ctrl_word(1, 0));
    @(negedge clk); cpu_wfi = 1; @(negedge clk); cpu_wfi = 0; repeat (2) @(negedge clk);
    check(reg_en == 1, "R10 no sleepdeep stays run", 32'(reg_en), 1);

    // R7: reset pin while running
    @(negedge clk); rst_pin_n = 0; repeat (3) @(negedge clk);
    check(sys_rst_req == 1, "R7 pin passes in run", 32'(sys_rst_req), 1);
    rst_pin_n = 1; repeat (3) @(negedge clk);
    check(sys_rst_req == 0, "R7 pin release", 32'(sys_rst_req), 0);

    // R8: wake pin low at entry
    @(negedge clk); wake_n = 0; repeat (3) @(negedge clk);
    enter_dpd(); repeat (4) @(negedge clk);
    check(reg_en == 1 && sys_rst_req == 0, "R8 low wake blocks entry", {reg_en, sys_rst_req}, 32'h2);
    wake_n = 1; repeat (3) @(negedge clk);

    // R9: back-pressure
    bus_wr(1, 32'hA5A5_0001); bus_wr(2, 32'h5A5A_0002);
    @(negedge clk); rsp_ready = 0; req_valid = 1; req_write = 0; req_addr = 1;
    @(negedge clk); req_addr = 2;
    check(rsp_valid == 1 && req_ready == 0, "R9 stall drops ready", {rsp_valid, req_ready}, 32'h2);
    hold = rsp_rdata;
    repeat (3) @(negedge clk);
    check(rsp_valid == 1 && rsp_rdata == hold, "R9 response held", rsp_rdata, hold);
    check(hold == 32'hA5A5_0001, "R9 stalled read data", hold, 32'hA5A5_0001);
    rsp_ready = 1;
    @(negedge clk); req_valid = 0;
    check(rsp_rdata == 32'h5A5A_0002, "R9 read after stall", rsp_rdata, 32'h5A5A_0002);

    // random rounds
    for (int it = 0; it < 6; it++) begin
      int len;
      for (int i = 0; i < NUM_RET; i++) begin
        vals[i] = $urandom;
        bus_wr(3'(i + 1), vals[i]);
      end
      bus_wr(0, ctrl_word(1, 1));
      enter_dpd();
      check(reg_en == 0, "R1 entered power-down", 32'(reg_en), 0);
      if (it % 2 == 0) begin
        rst_pin_n = 0; repeat (4) @(negedge clk);
        check(sys_rst_req == 0 && reg_en == 0, "R7 pin ignored in power-down", {reg_en, sys_rst_req}, 0);
        rst_pin_n = 1; repeat (3) @(negedge clk);
      end
      len = WAKE_MIN - 3 + int'($urandom % 7);
      if (it == 0) len = WAKE_MIN - 1;
      if (it == 1) len = WAKE_MIN;
      wake_pulse(len);
      check(reg_en == should_wake(len), "R2 pulse qualification", 32'(reg_en), 32'(should_wake(len)));
      if (!should_wake(len)) wake_pulse(WAKE_MIN + 2);
      finish_wake();
      for (int i = 0; i < NUM_RET; i++) begin
        bus_rd(3'(i + 1), rd);
        check(rd == vals[i], "R5 retention kept", rd, vals[i]);
      end
      bus_rd(0, rd); check(rd == ctrl_word(1, 1), "R6 flag set after wake", rd, ctrl_word(1, 1));
      bus_wr(0, ctrl_word(1, 0));
      bus_rd(0, rd); check(rd == ctrl_word(1, 1), "R6 zero write keeps flag", rd, ctrl_word(1, 1));
      bus_wr(0, ctrl_word(1, 1));
      bus_rd(0, rd); check(rd == ctrl_word(1, 0), "R6 flag write-one-clear", rd, ctrl_word(1, 0));
    end

    // POR clears retained state
    @(negedge clk); por_n = 0; repeat (2) @(negedge clk); por_n = 1; repeat (2) @(negedge clk);
    bus_rd(0, rd); check(rd == 0, "R5 POR clears control", rd, 0);
    bus_rd(2, rd); check(rd == 0, "R5 POR clears retention", rd, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule